// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single read or write requests from a processor core into timed cycles on an external asynchronous static-RAM bus. The bus has a 16-bit address and a 16-bit data path. Every transfer passes through four one-clock phases, T0 to T1 to T2 to T3. The address lines and a program-space or data-space select are registered at the start of T0 and held until T3 ends. The active-low read or write strobe falls at the start of T1 and rises at the start of T3. For a write, the data-pin direction turns outward together with the strobe, and the write data is driven from the start of T2. For a read, the input bus is captured on the clock edge that raises the read strobe.

The core presents a request with `req_valid` and keeps the request fields steady until `req_ack` pulses. The pulse comes one clock after T3. A new request is taken only while the sequencer is idle. Anything the core changes on the request inputs during a cycle has no effect on that cycle. When the core runs internal accesses in a low-power stop or wait state, a configuration bit chooses between two strobe behaviours: keep driving the strobes high, or release them to high impedance through `strobe_oe`. Under reset both strobes read high and are not driven.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high, and from the first clock edge it is sampled high: `rd_n`=1, `wr_n`=1, `strobe_oe`=0, `data_dir`=0, `data_oe`=0, `req_ack`=0, `sel_prog`=0, `sel_data`=0. This holds even when reset arrives in the middle of a cycle.
- R2: With `req_valid` high in idle, the accepting edge starts T0, and the next three edges start T1, T2 and T3. `req_ack` is 1 for exactly the clock after T3. The block then returns to idle. With `req_valid` low it stays idle with both strobes high.
- R3: In a write (`req_write`=1), `wr_n` is 0 during T1 and T2 and 1 from T3 on. `rd_n` stays 1.
- R4: In a write, `data_dir` (1 = pins drive outward) is 1 during T1 to T3. `data_oe` is 1 and `data_out` carries the write data during T2 and T3 only.
- R5: In a read, `rd_n` is 0 during T1 and T2 and 1 from T3 on. `wr_n` stays 1 and `data_dir` stays 0.
- R6: In a read, `data_in` sampled on the edge ending T2 appears on `rd_data` from T3. It is held until the next read.
- R7: `bus_addr` equals the request address from T0 through T3. `sel_prog`=1 for `req_space`=1 and `sel_data`=1 for `req_space`=0. Both selects are 0 outside T0 to T3.
- R8: `rd_n` and `wr_n` are never 0 at the same time.
- R9: Changes to `req_addr`, `req_write`, `req_space` or `req_wdata` after the accepting edge do not alter the cycle in flight.
- R10: Out of reset, `strobe_oe` is registered one clock after its inputs. It is 0 when idle with `low_power`=1 and `drv_hold`=0, and 1 in every other case, including throughout T0 to T3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core transfer request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| low_power | input | 1 | Core is in stop or wait state |
| drv_hold | input | 1 | Configuration bit: 1 keeps strobes driven in low power |
| bus_addr | output | 16 | External address lines |
| sel_prog | output | 1 | Program-space select |
| sel_data | output | 1 | Data-space select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| strobe_oe | output | 1 | Output enable for both strobe pads |
| data_dir | output | 1 | Data pin direction, 1 = output |
| data_oe | output | 1 | Data pin output enable |
| data_out | output | 16 | Data driven onto the bus |
| data_in | input | 16 | Data read from the bus |

## Verification
A wrong phase register shows up as a strobe edge that comes one clock early or late. It can also show up as an acknowledge that never arrives. Either is visible at the ports within six clocks of acceptance. A corrupted latched operation flag shows up as the wrong strobe falling in T1, or as `data_oe` rising during a read, and both appear within two clocks. A corrupted address or select latch shows on `bus_addr` and the selects while a strobe is low. Because the bench memory stores and returns data through the same addresses, the error also resurfaces as wrong read data later in the run.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T0   = 3'd1,
    PH_T1   = 3'd2,
    PH_T2   = 3'd3,
    PH_T3   = 3'd4,
    PH_ACK  = 3'd5
  } bus_phase_e;
endpackage

// File: rtl/bus_phase_ctrl.sv
module bus_phase_ctrl
  import ext_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output bus_phase_e phase_q,
  output bus_phase_e phase_d,
  output logic       accept
);
  always_comb begin
    accept  = (phase_q == PH_IDLE) && req_valid;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_T0;
      PH_T0:   phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_ACK;
      PH_ACK:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  // R2: once started, a cycle never falls back to idle before acknowledging
  p_no_abort_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q inside {PH_T0, PH_T1, PH_T2, PH_T3}) |=> (phase_q != PH_IDLE));
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import ext_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_phase_e phase_d,
  input  logic       op_wr,
  input  logic       low_power,
  input  logic       drv_hold,
  output logic       rd_n,
  output logic       wr_n,
  output logic       strobe_oe,
  output logic       data_dir,
  output logic       data_oe,
  output logic       req_ack
);
  logic strobe_win, dir_win, drive_win;

  always_comb begin
    strobe_win = (phase_d == PH_T1) || (phase_d == PH_T2);
    dir_win    = strobe_win || (phase_d == PH_T3);
    drive_win  = (phase_d == PH_T2) || (phase_d == PH_T3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      strobe_oe <= 1'b0;
      data_dir  <= 1'b0;
      data_oe   <= 1'b0;
      req_ack   <= 1'b0;
    end else begin
      rd_n      <= !(strobe_win && !op_wr);
      wr_n      <= !(strobe_win && op_wr);
      data_dir  <= dir_win && op_wr;
      data_oe   <= drive_win && op_wr;
      req_ack   <= (phase_d == PH_ACK);
      strobe_oe <= (phase_d != PH_IDLE) || !low_power || drv_hold;
    end
  end

  // R4: pins never drive outward while a read strobe is active
  p_oe_needs_dir_r4: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_dir && rd_n));
  // R4: a falling write strobe is followed by write data on the bus
  p_wr_then_drive_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |=> data_oe);
  // R2: acknowledge lasts one clock
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
endmodule

// File: rtl/bus_data_path.sv
module bus_data_path
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  bus_phase_e    phase_q,
  input  bus_phase_e    phase_d,
  input  logic          req_write,
  input  logic          req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] data_in,
  output logic          op_wr,
  output logic [AW-1:0] bus_addr,
  output logic          sel_prog,
  output logic          sel_data,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_wr    <= 1'b0;
      bus_addr <= '0;
      data_out <= '0;
    end else if (accept) begin
      op_wr    <= req_write;
      bus_addr <= req_addr;
      data_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prog <= 1'b0;
      sel_data <= 1'b0;
    end else if (accept) begin
      sel_prog <= req_space;
      sel_data <= !req_space;
    end else if (phase_d == PH_ACK || phase_d == PH_IDLE) begin
      sel_prog <= 1'b0;
      sel_data <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               rd_data <= '0;
    else if (phase_q == PH_T2 && !op_wr)   rd_data <= data_in;
  end

  // R9: the latched operation cannot change while a cycle is in flight
  p_op_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q inside {PH_T0, PH_T1, PH_T2}) |=> $stable(op_wr) && $stable(bus_addr));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rd_data,
  input  logic          low_power,
  input  logic          drv_hold,
  output logic [AW-1:0] bus_addr,
  output logic          sel_prog,
  output logic          sel_data,
  output logic          rd_n,
  output logic          wr_n,
  output logic          strobe_oe,
  output logic          data_dir,
  output logic          data_oe,
  output logic [DW-1:0] data_out,
  input  logic [DW-1:0] data_in
);
  bus_phase_e phase_q, phase_d;
  logic       accept;
  logic       op_wr;

  bus_phase_ctrl u_phase (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .phase_q(phase_q), .phase_d(phase_d), .accept(accept)
  );

  bus_strobe_gen u_strobe (
    .clk(clk), .rst(rst), .phase_d(phase_d), .op_wr(op_wr),
    .low_power(low_power), .drv_hold(drv_hold),
    .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
    .data_dir(data_dir), .data_oe(data_oe), .req_ack(req_ack)
  );

  bus_data_path #(.AW(AW), .DW(DW)) u_data (
    .clk(clk), .rst(rst), .accept(accept), .phase_q(phase_q), .phase_d(phase_d),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .data_in(data_in), .op_wr(op_wr),
    .bus_addr(bus_addr), .sel_prog(sel_prog), .sel_data(sel_data),
    .data_out(data_out), .rd_data(rd_data)
  );

  // R8: strobes are mutually exclusive
  p_excl_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R7: address steady across consecutive strobe-low clocks
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |=> (rd_n && wr_n) || $stable(bus_addr));
  // R7: exactly one space select while a strobe is low
  p_sel_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> (sel_prog ^ sel_data));
  // R10: strobe pads are driven whenever a strobe is low
  p_strobe_driven_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> strobe_oe);
endmodule

// File: tb/sim_ext_bus_seq.sv
`timescale 1ns/1ps
module sim_ext_bus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_space = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        low_power = 1'b0, drv_hold = 1'b0;
  logic        req_ack, sel_prog, sel_data, rd_n, wr_n, strobe_oe, data_dir, data_oe;
  logic [15:0] rd_data, bus_addr, data_out, data_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] mem     [16];
  logic [15:0] exp_mem [16];

  always #2 clk = ~clk;

  ext_bus_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_data(rd_data), .low_power(low_power),
    .drv_hold(drv_hold), .bus_addr(bus_addr), .sel_prog(sel_prog),
    .sel_data(sel_data), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
    .data_dir(data_dir), .data_oe(data_oe), .data_out(data_out), .data_in(data_in)
  );

  // behavioural static RAM: output enabled by rd_n, written on wr_n rise
  assign data_in = !rd_n ? mem[bus_addr[3:0]] : 16'hDEAD;
  always @(posedge wr_n) if (!rst && data_oe) mem[bus_addr[3:0]] <= data_out;

  // {write, space, addr, wdata}
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 1'b0, 16'h0003, 16'hA5A5},
    {1'b1, 1'b1, 16'h0005, 16'h1234},
    {1'b0, 1'b0, 16'h0003, 16'h0000},
    {1'b0, 1'b1, 16'h0005, 16'h0000},
    {1'b0, 1'b0, 16'h000C, 16'h0000},
    {1'b1, 1'b0, 16'h0003, 16'h5A0F},
    {1'b0, 1'b1, 16'h0003, 16'h0000},
    {1'b1, 1'b1, 16'h000F, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic wr, input logic sp, input logic [15:0] a,
                      input logic [15:0] wd, input bit disturb);
    req_valid = 1'b1; req_write = wr; req_space = sp; req_addr = a; req_wdata = wd;
    tick(); // T0
    check("R7 addr in T0", {16'h0, bus_addr}, {16'h0, a});
    check("R7 selects in T0", {sel_prog, sel_data}, {sp, !sp});
    check("R2 strobes high in T0", {rd_n, wr_n}, 2'b11);
    if (disturb) begin
      req_addr = ~a; req_write = !wr; req_space = !sp; req_wdata = ~wd;
    end
    tick(); // T1
    check(disturb ? "R9 addr held T1" : "R7 addr held T1", {16'h0, bus_addr}, {16'h0, a});
    check("R10 strobe_oe in cycle", strobe_oe, 1'b1);
    if (wr) begin
      check("R3 wr_n low T1", {rd_n, wr_n}, 2'b10);
      check("R4 dir out T1", {data_dir, data_oe}, 2'b10);
    end else begin
      check("R5 rd_n low T1", {rd_n, wr_n}, 2'b01);
      check("R5 dir in T1", {data_dir, data_oe}, 2'b00);
    end
    tick(); // T2
    if (wr) begin
      check(disturb ? "R9 wr_n low T2" : "R3 wr_n low T2", {rd_n, wr_n}, 2'b10);
      check("R4 drive T2", {data_dir, data_oe}, 2'b11);
      check(disturb ? "R9 wdata T2" : "R4 wdata T2", {16'h0, data_out}, {16'h0, wd});
    end else begin
      check(disturb ? "R9 rd_n low T2" : "R5 rd_n low T2", {rd_n, wr_n}, 2'b01);
    end
    check("R7 selects T2", {sel_prog, sel_data}, {sp, !sp});
    tick(); // T3
    check(wr ? "R3 wr_n high T3" : "R5 rd_n high T3", {rd_n, wr_n}, 2'b11);
    if (wr) begin
      check("R4 drive T3", {data_dir, data_oe}, 2'b11);
      exp_mem[a[3:0]] = wd;
    end else begin
      check("R6 read data", {16'h0, rd_data}, {16'h0, exp_mem[a[3:0]]});
    end
    check("R2 no ack in T3", req_ack, 1'b0);
    tick(); // ack clock
    check("R2 ack pulse", req_ack, 1'b1);
    check("R7 selects dropped", {sel_prog, sel_data}, 2'b00);
    check("R4 bus released", {data_dir, data_oe}, 2'b00);
    req_valid = 1'b0;
    tick(); // idle
    check("R2 ack one clock", req_ack, 1'b0);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 16'h1000 + 16'(i) * 16'h0101;
      exp_mem[i] = 16'h1000 + 16'(i) * 16'h0101;
    end
    tick(); tick();
    check("R1 reset strobes", {rd_n, wr_n, strobe_oe}, 3'b110);
    check("R1 reset bus", {data_dir, data_oe, req_ack, sel_prog, sel_data}, 5'b0);
    #1 rst = 1'b0;
    tick();
    check("R10 driven when awake", strobe_oe, 1'b1);

    // R2: no request, nothing moves
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R2 idle without request", {rd_n, wr_n, req_ack, sel_prog, sel_data}, 5'b11000);
    end

    // vector walk
    for (int v = 0; v < 8; v++)
      xfer(VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0], 1'b0);

    // R6: rd_data holds after a write cycle
    xfer(1'b0, 1'b0, 16'h0007, 16'h0, 1'b0);
    xfer(1'b1, 1'b0, 16'h0008, 16'h4321, 1'b0);
    check("R6 rd_data held over write", {16'h0, rd_data}, {16'h0, exp_mem[7]});

    // R9: request fields change mid-cycle
    xfer(1'b1, 1'b1, 16'h0009, 16'hBEEF, 1'b1);
    xfer(1'b0, 1'b0, 16'h0009, 16'h0, 1'b1);

    // R10: low-power strobe release
    low_power = 1'b1; drv_hold = 1'b0;
    tick();
    check("R10 released in low power", strobe_oe, 1'b0);
    drv_hold = 1'b1;
    tick();
    check("R10 held driven by config", strobe_oe, 1'b1);
    drv_hold = 1'b0;
    tick();
    xfer(1'b0, 1'b1, 16'h0005, 16'h0, 1'b0);
    check("R10 released after cycle", strobe_oe, 1'b0);
    low_power = 1'b0;
    tick();
    check("R10 driven when awake again", strobe_oe, 1'b1);

    // R1: reset in the middle of a write
    req_valid = 1'b1; req_write = 1'b1; req_space = 1'b0; req_addr = 16'h0002; req_wdata = 16'h7777;
    tick(); tick(); tick(); // T2
    check("R3 wr_n low before reset", wr_n, 1'b0);
    rst = 1'b1; req_valid = 1'b0;
    tick();
    check("R1 mid-cycle reset strobes", {rd_n, wr_n, strobe_oe}, 3'b110);
    check("R1 mid-cycle reset bus", {data_dir, data_oe, req_ack, sel_prog, sel_data}, 5'b0);
    rst = 1'b0;
    tick();
    check("R2 idle after reset", {rd_n, wr_n, req_ack}, 3'b110);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule